// File: doc/BRIEF.md
# Destination-Routed Stream Crossbar

This block joins a set of streaming sources to a set of streaming sinks. Every frame that arrives on a source port is sent, whole and unchanged, to the single sink port whose destination window contains the frame's destination field. The choice is made on the frame's first beat and holds until its final beat has been taken. A frame whose destination lies in no window is accepted and discarded. A frame from a source that the chosen sink's connection mask excludes is handled the same way.

Each sink has its own round-robin arbiter. When several sources want one sink at once, the arbiter grants one whole frame at a time. Every sink port can be given an optional two-entry register slice with a registered ready, so that long routes can be timed without losing throughput. The default build has four sources and four sinks, 64-bit data with an 8-bit byte-keep field, an 8-bit id, a 3-bit destination and a 1-bit user field.

Top module: `strm_xbar`

## Requirements
- R1: While reset is held, and on the first cycle after it is released with no source valid, every sink valid is 0 and every source ready is 0.
- R2: A frame whose first-beat destination d satisfies BASE[j] <= d <= TOP[j] leaves on sink j (default windows: sink j takes destination j only), with data, keep and last bits identical to the input beats.
- R3: The id, destination and user fields of every beat appear unchanged on the sink beat that carries it.
- R4: A frame whose destination lies in no window (for example 4 or 5) is fully accepted at its source and appears on no sink, and frames sent at the same time on other sources are still delivered intact.
- R5: Bit j*N_IN+i of the connection mask cleared means source i cannot reach sink j; such a frame is consumed and dropped as in R4 (the bench clears bit 13, cutting source 1 from sink 3).
- R6: The route is fixed by the first beat and held until the beat with last set is accepted; a later beat whose destination field differs does not move the frame, and beats of different frames never interleave on one sink.
- R7: Each sink's arbiter searches upward, with wrap, from the source after the one most recently granted, starting at source 0 after reset, and holds its grant for a whole frame.
- R8: Under any pattern of source valid gaps and sink ready stalls, frames from one source reach each sink complete and in their send order.
- R9: Once a sink presents a beat, it keeps valid high and the beat unchanged until the sink's ready is seen high.
- R10: The byte-keep field is DATA_W/8 bits wide when DATA_W exceeds 8 bits; otherwise it is one bit, tied to 1 at the sinks.
- R11: With sinks always ready and sources not paused, the beats of a frame leave the sink on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | N_IN | Source beat valid, one bit per source |
| in_ready | output | N_IN | Source beat ready, one bit per source |
| in_data | input | N_IN*DATA_W | Source data, source i in slice i |
| in_keep | input | N_IN*KW | Source byte-keep |
| in_last | input | N_IN | Source last-beat flag |
| in_id | input | N_IN*ID_W | Source id field |
| in_dest | input | N_IN*DST_W | Source destination field |
| in_user | input | N_IN*USER_W | Source user field |
| out_valid | output | N_OUT | Sink beat valid |
| out_ready | input | N_OUT | Sink beat ready |
| out_data | output | N_OUT*DATA_W | Sink data |
| out_keep | output | N_OUT*KW | Sink byte-keep |
| out_last | output | N_OUT | Sink last-beat flag |
| out_id | output | N_OUT*ID_W | Sink id field |
| out_dest | output | N_OUT*DST_W | Sink destination field |
| out_user | output | N_OUT*USER_W | Sink user field |

## Verification
Discarding a frame and delivering a frame can happen in the same cycle. In the drop scenario, sources 2 and 3 push destinations 4 and 5 while sources 0 and 1 send to sinks 0 and 1, and the sinks stall at random. The bench judges this by checking that every dropped beat is drained at its source, that no dropped tag ever completes on a sink, and that the delivered frames arrive beat-exact. A second collision is a frame ending on a sink in the same cycle as a new request for it. The round-robin scenario provokes this with simultaneous requests after a reset and checks the order in which frames complete.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int XB_MAX = 32;

  // inclusive window test on a zero-extended destination
  function automatic logic in_window(input logic [15:0] d, input logic [15:0] lo,
                                     input logic [15:0] hi);
    return (d >= lo) && (d <= hi);
  endfunction

  // lowest set bit among the first n, or -1
  function automatic int lowest_set(input logic [XB_MAX-1:0] v, input int n);
    int r;
    r = -1;
    for (int k = XB_MAX - 1; k >= 0; k--)
      if (k < n && v[k]) r = k;
    return r;
  endfunction

  // first requester at or above ptr, wrapping at n, or -1
  function automatic int rr_pick(input logic [XB_MAX-1:0] req, input int n, input int ptr);
    int r;
    int idx;
    r = -1;
    for (int k = XB_MAX - 1; k >= 0; k--) begin
      if (k < n) begin
        idx = ptr + k;
        if (idx >= n) idx = idx - n;
        if (req[idx]) r = idx;
      end
    end
    return r;
  endfunction

  function automatic int rr_next(input int w, input int n);
    return (w + 1 >= n) ? 0 : w + 1;
  endfunction
endpackage

// File: rtl/xbar_route.sv
module xbar_route
  import xbar_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int DST_W = 3,
  parameter int SRC   = 0,
  parameter logic [N_OUT*DST_W-1:0] BASE = '0,
  parameter logic [N_OUT*DST_W-1:0] TOP  = '0,
  parameter logic [N_OUT*N_IN-1:0]  CONN = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic             rdy,
  input  logic [DST_W-1:0] dest,
  input  logic             last,
  output logic [N_OUT-1:0] sel,
  output logic             drop
);
  logic [N_OUT-1:0] hit;
  logic [N_OUT-1:0] dec_sel;
  logic [N_OUT-1:0] lsel_q;
  logic             ldrop_q;
  logic             lock_q;
  logic             acc;
  int               w;

  for (genvar o = 0; o < N_OUT; o++) begin : g_hit
    assign hit[o] = in_window(16'(dest), 16'(BASE[o*DST_W +: DST_W]),
                              16'(TOP[o*DST_W +: DST_W])) && CONN[o*N_IN + SRC];
  end

  always_comb begin
    w       = lowest_set(XB_MAX'(hit), N_OUT);
    dec_sel = (w >= 0) ? (N_OUT'(1) << w) : '0;
  end

  assign sel  = lock_q ? lsel_q  : dec_sel;
  assign drop = lock_q ? ldrop_q : (dec_sel == '0);
  assign acc  = vld && rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q  <= 1'b0;
      lsel_q  <= '0;
      ldrop_q <= 1'b0;
    end else if (acc) begin
      if (last) begin
        lock_q <= 1'b0;
      end else begin
        lock_q  <= 1'b1;
        lsel_q  <= sel;
        ldrop_q <= drop;
      end
    end
  end

  // R6
  route_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !last) |=> (sel == $past(sel)) && (drop == $past(drop)));
endmodule

// File: rtl/xbar_arb.sv
module xbar_arb
  import xbar_pkg::*;
#(
  parameter int N_IN = 4,
  localparam int PW = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] req,
  input  logic            fire,
  input  logic            last,
  output logic [N_IN-1:0] gnt
);
  logic [PW-1:0]   ptr_q;
  logic [N_IN-1:0] hold_q;
  logic            active_q;
  int              pick;

  always_comb begin
    pick = rr_pick(XB_MAX'(req), N_IN, int'(ptr_q));
    if (active_q)       gnt = hold_q;
    else if (pick >= 0) gnt = N_IN'(1) << pick;
    else                gnt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q    <= '0;
      hold_q   <= '0;
      active_q <= 1'b0;
    end else if (fire) begin
      if (!active_q) ptr_q <= PW'(rr_next(pick, N_IN));
      if (last) begin
        active_q <= 1'b0;
      end else begin
        active_q <= 1'b1;
        hold_q   <= gnt;
      end
    end
  end

  // R6
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !last) |=> (gnt == $past(gnt)));

  // R7
  rr_fair_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && last && |(req & ~gnt)) |=> (gnt != $past(gnt)) && (gnt != '0));
endmodule

// File: rtl/xbar_slice.sv
module xbar_slice #(
  parameter int W   = 8,
  parameter bit REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  if (REG) begin : g_skid
    logic [W-1:0] main_q;
    logic [W-1:0] skid_q;
    logic         mv_q;
    logic         sv_q;

    assign in_ready  = !sv_q;
    assign out_valid = mv_q;
    assign out_data  = main_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        mv_q   <= 1'b0;
        sv_q   <= 1'b0;
        main_q <= '0;
        skid_q <= '0;
      end else if (!mv_q || out_ready) begin
        if (sv_q) begin
          main_q <= skid_q;
          mv_q   <= 1'b1;
          sv_q   <= 1'b0;
        end else begin
          mv_q <= in_valid;
          if (in_valid) main_q <= in_data;
        end
      end else if (in_valid && !sv_q) begin
        skid_q <= in_data;
        sv_q   <= 1'b1;
      end
    end

    // R1
    slice_reset_chk: assert property (@(posedge clk) rst |=> !out_valid);
  end else begin : g_pass
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data));
endmodule

// File: rtl/strm_xbar.sv
module strm_xbar
  import xbar_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 4,
  parameter int DATA_W = 64,
  parameter int ID_W   = 8,
  parameter int DST_W  = $clog2(N_OUT + 1),
  parameter int USER_W = 1,
  parameter logic [N_OUT*DST_W-1:0] BASE = 12'b011_010_001_000,
  parameter logic [N_OUT*DST_W-1:0] TOP  = 12'b011_010_001_000,
  parameter logic [N_OUT*N_IN-1:0]  CONN = {(N_OUT*N_IN){1'b1}},
  parameter bit OUT_REG = 1'b1,
  localparam bit KEEP_ON = (DATA_W > 8),
  localparam int KW = KEEP_ON ? DATA_W / 8 : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_IN-1:0]         in_valid,
  output logic [N_IN-1:0]         in_ready,
  input  logic [N_IN*DATA_W-1:0]  in_data,
  input  logic [N_IN*KW-1:0]      in_keep,
  input  logic [N_IN-1:0]         in_last,
  input  logic [N_IN*ID_W-1:0]    in_id,
  input  logic [N_IN*DST_W-1:0]   in_dest,
  input  logic [N_IN*USER_W-1:0]  in_user,
  output logic [N_OUT-1:0]        out_valid,
  input  logic [N_OUT-1:0]        out_ready,
  output logic [N_OUT*DATA_W-1:0] out_data,
  output logic [N_OUT*KW-1:0]     out_keep,
  output logic [N_OUT-1:0]        out_last,
  output logic [N_OUT*ID_W-1:0]   out_id,
  output logic [N_OUT*DST_W-1:0]  out_dest,
  output logic [N_OUT*USER_W-1:0] out_user
);
  // beat layout, low to high: user, dest, id, last, keep, data
  localparam int P_DST  = USER_W;
  localparam int P_ID   = P_DST + DST_W;
  localparam int P_LAST = P_ID + ID_W;
  localparam int P_KEEP = P_LAST + 1;
  localparam int P_DATA = P_KEEP + KW;
  localparam int PW     = P_DATA + DATA_W;

  logic [PW-1:0]    pay    [N_IN];
  logic [N_OUT-1:0] sel    [N_IN];
  logic [N_IN-1:0]  drop_w;
  logic [N_IN-1:0]  gcol;
  logic [N_IN-1:0]  req    [N_OUT];
  logic [N_IN-1:0]  gnt    [N_OUT];
  logic [PW-1:0]    mux_d  [N_OUT];
  logic [PW-1:0]    slc_d  [N_OUT];
  logic [N_OUT-1:0] mux_v;
  logic [N_OUT-1:0] slc_rdy;
  logic [N_OUT-1:0] fire;

  // source side: pack, decode and lock the route
  for (genvar i = 0; i < N_IN; i++) begin : g_src
    logic [KW-1:0] keep_i;
    if (KEEP_ON) begin : g_keep
      assign keep_i = in_keep[i*KW +: KW];
    end else begin : g_nokeep
      assign keep_i = '1;
    end

    assign pay[i] = {in_data[i*DATA_W +: DATA_W], keep_i, in_last[i],
                     in_id[i*ID_W +: ID_W], in_dest[i*DST_W +: DST_W],
                     in_user[i*USER_W +: USER_W]};

    xbar_route #(
      .N_IN(N_IN), .N_OUT(N_OUT), .DST_W(DST_W), .SRC(i),
      .BASE(BASE), .TOP(TOP), .CONN(CONN)
    ) i_route (
      .clk (clk),
      .rst (rst),
      .vld (in_valid[i]),
      .rdy (in_ready[i]),
      .dest(in_dest[i*DST_W +: DST_W]),
      .last(in_last[i]),
      .sel (sel[i]),
      .drop(drop_w[i])
    );

    always_comb begin
      gcol[i] = 1'b0;
      in_ready[i] = drop_w[i];
      for (int o = 0; o < N_OUT; o++) begin
        gcol[i] = gcol[i] | gnt[o][i];
        if (gnt[o][i] && slc_rdy[o]) in_ready[i] = 1'b1;
      end
      in_ready[i] = in_ready[i] && in_valid[i];
    end

    // R4
    drop_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid[i] && drop_w[i]) |-> !gcol[i]);
  end

  // sink side: arbitrate, steer and register
  for (genvar o = 0; o < N_OUT; o++) begin : g_dst
    always_comb begin
      for (int i = 0; i < N_IN; i++) req[o][i] = in_valid[i] && sel[i][o];
    end

    always_comb begin
      mux_d[o] = '0;
      for (int i = 0; i < N_IN; i++)
        if (gnt[o][i]) mux_d[o] = mux_d[o] | pay[i];
    end

    assign mux_v[o] = |(req[o] & gnt[o]);
    assign fire[o]  = mux_v[o] && slc_rdy[o];

    xbar_arb #(.N_IN(N_IN)) i_arb (
      .clk (clk),
      .rst (rst),
      .req (req[o]),
      .fire(fire[o]),
      .last(mux_d[o][P_LAST]),
      .gnt (gnt[o])
    );

    xbar_slice #(.W(PW), .REG(OUT_REG)) i_slice (
      .clk      (clk),
      .rst      (rst),
      .in_valid (mux_v[o]),
      .in_data  (mux_d[o]),
      .in_ready (slc_rdy[o]),
      .out_valid(out_valid[o]),
      .out_data (slc_d[o]),
      .out_ready(out_ready[o])
    );

    assign out_data[o*DATA_W +: DATA_W] = slc_d[o][P_DATA +: DATA_W];
    assign out_keep[o*KW +: KW]         = KEEP_ON ? slc_d[o][P_KEEP +: KW] : '1;
    assign out_last[o]                  = slc_d[o][P_LAST];
    assign out_id[o*ID_W +: ID_W]       = slc_d[o][P_ID +: ID_W];
    assign out_dest[o*DST_W +: DST_W]   = slc_d[o][P_DST +: DST_W];
    assign out_user[o*USER_W +: USER_W] = slc_d[o][0 +: USER_W];
  end
endmodule

// File: tb/test_strm_xbar.sv
module test_strm_xbar;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int DW = 64;
  localparam int KW = 8;
  localparam int IW = 8;
  localparam int DSW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NI-1:0]     in_valid = '0;
  logic [NI-1:0]     in_ready;
  logic [NI*DW-1:0]  in_data = '0;
  logic [NI*KW-1:0]  in_keep = '0;
  logic [NI-1:0]     in_last = '0;
  logic [NI*IW-1:0]  in_id = '0;
  logic [NI*DSW-1:0] in_dest = '0;
  logic [NI-1:0]     in_user = '0;
  logic [NO-1:0]     out_valid;
  logic [NO-1:0]     out_ready = '0;
  logic [NO*DW-1:0]  out_data;
  logic [NO*KW-1:0]  out_keep;
  logic [NO-1:0]     out_last;
  logic [NO*IW-1:0]  out_id;
  logic [NO*DSW-1:0] out_dest;
  logic [NO-1:0]     out_user;

  strm_xbar #(.CONN(16'hDFFF)) i_strm_xbar (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_keep(in_keep),
    .in_last(in_last), .in_id(in_id), .in_dest(in_dest), .in_user(in_user),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_keep(out_keep),
    .out_last(out_last), .out_id(out_id), .out_dest(out_dest), .out_user(out_user)
  );

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  // source queues
  logic [63:0] sm_data [NI][256];
  logic [7:0]  sm_keep [NI][256];
  logic        sm_last [NI][256];
  logic [7:0]  sm_id   [NI][256];
  logic [2:0]  sm_dest [NI][256];
  logic        sm_user [NI][256];
  int wr [NI];
  int rd [NI];
  bit vld [NI];
  bit acc [NI];

  // frame registry, indexed by tag
  int fr_out [256];
  int fr_dst [256];
  bit fr_chg [256];
  int fr_got [256];
  int nfr = 0;

  int ord_tag [NO][64];
  int ord_cnt [NO];
  int last_tag [NI][NO];
  int nxt_b [NO];
  int cur_tag [NO];
  longint prev_cyc [NO];
  bit prev_stall [NO];
  logic [63:0] prev_dat [NO];

  bit strict_tp = 1'b0;
  bit src_pause_en = 1'b0;
  bit snk_pause_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  longint cyc = 0;

  function automatic bit routable(input int s, input int d);
    return (d < 4) && !(s == 1 && d == 3);
  endfunction

  function automatic logic [7:0] exp_keep(input int b, input int n);
    return (b == n - 1) ? 8'h0F : 8'hFF;
  endfunction

  task automatic send(input int s, input int d, input int n, input bit chg);
    int t;
    t = nfr;
    nfr++;
    fr_out[t] = routable(s, d) ? d : -1;
    fr_dst[t] = d;
    fr_chg[t] = chg;
    fr_got[t] = 0;
    for (int b = 0; b < n; b++) begin
      sm_data[s][wr[s]] = {8'hA5, 8'(s), 16'(t), 8'(d), 8'(b), 16'(n)};
      sm_keep[s][wr[s]] = exp_keep(b, n);
      sm_last[s][wr[s]] = (b == n - 1);
      sm_id[s][wr[s]]   = {4'(s), 4'(t)};
      sm_dest[s][wr[s]] = (chg && b > 0) ? 3'(d + 1) : 3'(d);
      sm_user[s][wr[s]] = 1'(t) ^ 1'(b);
      wr[s]++;
    end
  endtask

  // driver: inputs change 1 ns after the rising edge
  initial forever begin
    @(posedge clk);
    #1;
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    for (int i = 0; i < NI; i++) begin
      if (rst) vld[i] = 1'b0;
      else begin
        if (acc[i]) begin
          rd[i]++;
          vld[i] = 1'b0;
        end
        if (!vld[i] && rd[i] < wr[i] && !(src_pause_en && lfsr[i])) vld[i] = 1'b1;
      end
      in_valid[i]          = vld[i];
      in_data[i*DW +: DW]  = sm_data[i][rd[i]];
      in_keep[i*KW +: KW]  = sm_keep[i][rd[i]];
      in_last[i]           = sm_last[i][rd[i]];
      in_id[i*IW +: IW]    = sm_id[i][rd[i]];
      in_dest[i*DSW +: DSW] = sm_dest[i][rd[i]];
      in_user[i]           = sm_user[i][rd[i]];
    end
    for (int o = 0; o < NO; o++) out_ready[o] = !(snk_pause_en && lfsr[o+8]);
  end

  // monitor: samples at the falling edge
  initial forever begin
    @(negedge clk);
    for (int i = 0; i < NI; i++) acc[i] = in_valid[i] && in_ready[i];
    for (int o = 0; o < NO; o++) begin
      logic [63:0] d;
      int s, t, b, n, ed;
      d = out_data[o*DW +: DW];
      if (!rst && prev_stall[o])
        chk(out_valid[o] && d == prev_dat[o], "R9", "held beat", longint'(d), longint'(prev_dat[o]));
      prev_stall[o] = out_valid[o] && !out_ready[o];
      prev_dat[o] = d;
      if (!rst && out_valid[o] && out_ready[o]) begin
        s = int'(d[55:48]);
        t = int'(d[47:32]);
        b = int'(d[23:16]);
        n = int'(d[15:0]);
        if (nxt_b[o] == 0) cur_tag[o] = t;
        chk(t == cur_tag[o] && b == nxt_b[o], "R6", "beat sequence",
            longint'(t * 256 + b), longint'(cur_tag[o] * 256 + nxt_b[o]));
        chk(out_keep[o*KW +: KW] == exp_keep(b, n) && out_last[o] == (b == n - 1),
            "R2", "keep/last", longint'({out_keep[o*KW +: KW], out_last[o]}),
            longint'({exp_keep(b, n), 1'(b == n - 1)}));
        ed = (fr_chg[t] && b > 0) ? fr_dst[t] + 1 : fr_dst[t];
        chk(out_id[o*IW +: IW] == {4'(s), 4'(t)} && int'(out_dest[o*DSW +: DSW]) == ed
            && out_user[o] == (1'(t) ^ 1'(b)), "R3", "sideband",
            longint'({out_id[o*IW +: IW], out_dest[o*DSW +: DSW], out_user[o]}),
            longint'({4'(s), 4'(t), 3'(ed), 1'(t) ^ 1'(b)}));
        if (strict_tp && b > 0)
          chk(cyc == prev_cyc[o] + 1, "R11", "beat spacing", cyc, prev_cyc[o] + 1);
        prev_cyc[o] = cyc;
        nxt_b[o] = out_last[o] ? 0 : b + 1;
        if (out_last[o]) begin
          fr_got[t]++;
          chk(fr_out[t] == o, "R2", "frame sink", longint'(o), longint'(fr_out[t]));
          chk(t > last_tag[s][o], "R8", "send order", longint'(t), longint'(last_tag[s][o]));
          last_tag[s][o] = t;
          ord_tag[o][ord_cnt[o]] = t;
          ord_cnt[o]++;
        end
      end
    end
  end

  task automatic wait_drain();
    bit busy;
    busy = 1'b1;
    while (busy) begin
      @(negedge clk);
      busy = 1'b0;
      for (int i = 0; i < NI; i++) if (rd[i] < wr[i] || vld[i]) busy = 1'b1;
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic verify(input int lo, input string rq);
    for (int t = lo; t < nfr; t++) begin
      if (fr_out[t] >= 0) chk(fr_got[t] == 1, rq, "delivered once", longint'(fr_got[t]), 1);
      else chk(fr_got[t] == 0, rq, "dropped frame seen", longint'(fr_got[t]), 0);
    end
    for (int i = 0; i < NI; i++)
      chk(rd[i] == wr[i], "R4", "source drained", longint'(rd[i]), longint'(wr[i]));
  endtask

  task automatic t_reset();
    // R1
    chk(out_valid == '0 && in_ready == '0, "R1", "idle during reset",
        longint'({out_valid, in_ready}), 0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(out_valid == '0 && in_ready == '0, "R1", "idle after reset",
        longint'({out_valid, in_ready}), 0);
    // R10
    chk($bits(out_keep) == NO * DW / 8, "R10", "keep width", longint'($bits(out_keep)), NO * DW / 8);
  endtask

  task automatic t_straight(input bit sp, input bit kp);
    int lo;
    lo = nfr;
    src_pause_en = sp;
    snk_pause_en = kp;
    strict_tp = !sp && !kp;
    for (int i = 0; i < NI; i++) begin
      send(i, i, 4, 1'b0);
      send(i, i, 1, 1'b0);
    end
    wait_drain();
    strict_tp = 1'b0;
    verify(lo, "R2"); // R2 R11
  endtask

  task automatic t_swap();
    int lo;
    lo = nfr;
    src_pause_en = 1'b1;
    snk_pause_en = 1'b1;
    send(0, 3, 3, 1'b0);
    send(1, 2, 2, 1'b0);
    send(2, 1, 5, 1'b0);
    send(3, 0, 1, 1'b0);
    wait_drain();
    verify(lo, "R2");
  endtask

  task automatic t_fanin();
    int lo;
    lo = nfr;
    src_pause_en = 1'b1;
    snk_pause_en = 1'b1;
    for (int i = 0; i < NI; i++) begin
      send(i, 0, 3, 1'b0);
      send(i, 0, 1, 1'b0);
      send(i, 0, 2, 1'b0);
    end
    wait_drain();
    verify(lo, "R8");
  endtask

  task automatic t_fanout();
    int lo;
    lo = nfr;
    src_pause_en = 1'b0;
    snk_pause_en = 1'b1;
    for (int d = 0; d < NO; d++) send(0, d, 2, 1'b0);
    send(0, 2, 3, 1'b0);
    wait_drain();
    verify(lo, "R8");
  endtask

  task automatic t_drop();
    int lo;
    lo = nfr;
    src_pause_en = 1'b0;
    snk_pause_en = 1'b1;
    send(0, 0, 4, 1'b0);
    send(1, 1, 3, 1'b0);
    send(2, 4, 3, 1'b0);
    send(3, 5, 2, 1'b0);
    send(2, 2, 2, 1'b0);
    wait_drain();
    verify(lo, "R4");
  endtask

  task automatic t_mask();
    int lo;
    lo = nfr;
    src_pause_en = 1'b1;
    snk_pause_en = 1'b0;
    send(1, 3, 2, 1'b0);
    send(0, 3, 2, 1'b0);
    send(1, 2, 2, 1'b0);
    wait_drain();
    verify(lo, "R5");
  endtask

  task automatic t_lock();
    int lo;
    lo = nfr;
    src_pause_en = 1'b0;
    snk_pause_en = 1'b1;
    send(0, 1, 4, 1'b1);
    send(2, 2, 3, 1'b0);
    wait_drain();
    verify(lo, "R6");
  endtask

  task automatic t_rr();
    int base0, t1, t2, t3, t0;
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    src_pause_en = 1'b0;
    snk_pause_en = 1'b0;
    base0 = ord_cnt[0];
    t2 = nfr; send(2, 0, 2, 1'b0);
    t1 = nfr; send(1, 0, 2, 1'b0);
    wait_drain();
    t0 = nfr; send(0, 0, 2, 1'b0);
    t3 = nfr; send(3, 0, 2, 1'b0);
    wait_drain();
    chk(ord_cnt[0] == base0 + 4, "R7", "frame count", longint'(ord_cnt[0] - base0), 4);
    chk(ord_tag[0][base0] == t1, "R7", "1st grant", longint'(ord_tag[0][base0]), longint'(t1));
    chk(ord_tag[0][base0+1] == t2, "R7", "2nd grant", longint'(ord_tag[0][base0+1]), longint'(t2));
    chk(ord_tag[0][base0+2] == t3, "R7", "3rd grant", longint'(ord_tag[0][base0+2]), longint'(t3));
    chk(ord_tag[0][base0+3] == t0, "R7", "4th grant", longint'(ord_tag[0][base0+3]), longint'(t0));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    for (int i = 0; i < NI; i++) begin
      wr[i] = 0; rd[i] = 0; vld[i] = 1'b0; acc[i] = 1'b0;
      for (int o = 0; o < NO; o++) last_tag[i][o] = -1;
      for (int k = 0; k < 256; k++) begin
        sm_data[i][k] = '0; sm_keep[i][k] = '0; sm_last[i][k] = 1'b0;
        sm_id[i][k] = '0; sm_dest[i][k] = '0; sm_user[i][k] = 1'b0;
      end
    end
    for (int o = 0; o < NO; o++) begin
      ord_cnt[o] = 0; nxt_b[o] = 0; cur_tag[o] = 0; prev_cyc[o] = 0;
      prev_stall[o] = 1'b0; prev_dat[o] = '0;
    end
    repeat (4) @(negedge clk);
    t_reset();
    t_straight(1'b0, 1'b0);
    t_straight(1'b1, 1'b0);
    t_straight(1'b0, 1'b1);
    t_swap();
    t_fanin();
    t_fanout();
    t_drop();
    t_mask();
    t_lock();
    t_rr();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R8 watchdog act=running exp=finished");
    summary();
    $finish;
  end
endmodule